// File: doc/BRIEF.md
# Framed Serial Converter Word Loader

This block is the receiving end of a framed, DSP-style serial port that sets up a 12-bit digital-to-analogue converter. A host drives four pins: an active-low select, a frame marker, a serial clock and a data line. A faster system clock samples all four. A frame opens on a falling edge of the frame marker while the select is low. The block then takes in one bit on every falling serial-clock edge, most significant bit first, until it has sixteen bits.

After the sixteenth bit, the next rising edge of either the serial clock or the frame marker commits the word. Its low twelve bits go to a data latch, and two option bits go to a control latch. Bit 14 selects fast settling and bit 13 selects power-down. The converter's analogue path is not part of this block. A digital output stands in for it and shows the latched code, or zero while powered down.

The controller has three states:
- `ST_IDLE`: waits for a frame.
- `ST_SHIFT`: collects bits.
- `ST_ARMED`: sixteen bits are held and the block waits for the commit edge.

The transitions are:
- **open**: `ST_IDLE` or any other state goes to `ST_SHIFT` on a frame-marker fall with the select low.
- **full**: `ST_SHIFT` goes to `ST_ARMED` on the sixteenth serial-clock fall.
- **commit**: `ST_ARMED` goes to `ST_IDLE` on a serial-clock rise or a frame-marker rise.
- **drop**: any state goes to `ST_IDLE` when the select is high.

Top module: `sdac_rx`

## Requirements
- R1: After reset, `code_o`, `dac_o`, `fast_o`, `pdown_o` and `upd_o` are all zero.
- R2: With `cs_n_pin` low, a falling edge of `frm_pin` opens a frame. The sixteen following falling edges of `sck_pin` shift in bits 15 down to 0. The next rising `sck_pin` edge commits the word, and `code_o` then equals word bits 11..0.
- R3: Instead of a serial-clock rise, a rising edge of `frm_pin` after the sixteenth bit also commits the word.
- R4: Word bit 14 set to 1 makes `fast_o` 1 after the commit. Set to 0, it makes `fast_o` 0.
- R5: A committed word with bit 13 set makes `pdown_o` 1 and leaves `code_o` unchanged. While `pdown_o` is 1, `dac_o` reads zero.
- R6: `code_o` keeps its value through power-down. A later word with bit 13 clear makes `pdown_o` 0, and `dac_o` again equals `code_o`.
- R7: If `cs_n_pin` goes high before sixteen bits arrive, the partial word is dropped. `code_o`, `fast_o` and `pdown_o` stay unchanged and no strobe fires.
- R8: A new `frm_pin` falling edge in the middle of a frame restarts the bit count. Only the following complete word is committed.
- R9: `upd_o` is high for exactly one clock on every commit, including a power-down word. It is otherwise low, and no latch output changes without it.
- R10: While `cs_n_pin` is high, a complete frame has no effect on any output.
- R11: Word bits 15 and 12 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Active-low select from the host |
| frm_pin | input | 1 | Frame marker; a fall opens a frame |
| sck_pin | input | 1 | Serial clock; data taken on falling edges |
| sdi_pin | input | 1 | Serial data, MSB first |
| code_o | output | 12 | Held converter code |
| fast_o | output | 1 | Fast settling selected |
| pdown_o | output | 1 | Power-down selected |
| upd_o | output | 1 | One-cycle strobe on each commit |
| dac_o | output | 12 | Modelled converter output (zero in power-down) |

## Verification
The assertions take for granted that the host pins change slowly against `clk`. Each level is held for several system clocks, so every edge survives the synchronizers as one clean transition. They also assume the frame marker and the serial clock never switch in the same sampled cycle. The stimulus meets both assumptions: it changes each pin on a falling edge of `clk` and then waits four system clocks. It sets data well before the serial-clock fall that takes it, and it raises the frame marker only while the serial clock is parked.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 12;
    localparam int SPD_BIT = 14;
    localparam int PD_BIT = 13;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ARMED = 2'd2
    } rx_state_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
                else        chain <= {chain[STAGES-2:0], d_i[g]};
            end
            assign q_o[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sdac_frame_fsm.sv
module sdac_frame_fsm
    import sdac_pkg::*;
#(
    parameter int BITS = WORD_W,
    localparam int CNT_W = $clog2(BITS),
    localparam int SH_W = BITS - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            fs_fall,
    input  logic            fs_rise,
    input  logic            sck_fall,
    input  logic            sck_rise,
    input  logic            sdi,
    output logic [SH_W-1:0] payload_o,
    output logic            commit_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    rx_state_t state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else if (fs_fall) begin
            nxt = ST_SHIFT;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_SHIFT: if (sck_fall && cnt == LAST) nxt = ST_ARMED;
                ST_ARMED: if (sck_rise || fs_rise) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (en && fs_fall) begin
            cnt <= '0;
        end else if (en && state == ST_SHIFT && sck_fall) begin
            sh  <= {sh[SH_W-2:0], sdi};
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        commit_o  = en && !fs_fall && state == ST_ARMED && (sck_rise || fs_rise);
        payload_o = sh;
    end
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
    import sdac_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int PW = WORD_W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [PW-1:0] payload,
    output logic [CW-1:0] code_o,
    output logic          fast_o,
    output logic          pdown_o,
    output logic          upd_o,
    output logic [CW-1:0] dac_o
);
    logic unused_bits;
    assign unused_bits = ^payload[PW-1:CW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o  <= '0;
            fast_o  <= 1'b0;
            pdown_o <= 1'b0;
            upd_o   <= 1'b0;
        end else begin
            upd_o <= commit;
            if (commit) begin
                fast_o  <= payload[SPD_BIT];
                pdown_o <= payload[PD_BIT];
                if (!payload[PD_BIT]) code_o <= payload[CW-1:0];
            end
        end
    end

    always_comb dac_o = pdown_o ? '0 : code_o;
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BITS = WORD_W,
    parameter int CW = CODE_W,
    localparam int PW = BITS - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_pin,
    input  logic          frm_pin,
    input  logic          sck_pin,
    input  logic          sdi_pin,
    output logic [CW-1:0] code_o,
    output logic          fast_o,
    output logic          pdown_o,
    output logic          upd_o,
    output logic [CW-1:0] dac_o
);
    // bit order: 3 = select, 2 = frame, 1 = sclk, 0 = data
    localparam logic [3:0] IDLE_LVL = 4'b1110;

    logic [3:0] pins_s, pins_q;
    logic [PW-1:0] payload;
    logic commit;

    sdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({cs_n_pin, frm_pin, sck_pin, sdi_pin}),
        .q_o(pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= IDLE_LVL;
        else        pins_q <= pins_s;
    end

    sdac_frame_fsm #(.BITS(BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en(!pins_s[3]),
        .fs_fall(!pins_s[2] && pins_q[2]),
        .fs_rise(pins_s[2] && !pins_q[2]),
        .sck_fall(!pins_s[1] && pins_q[1]),
        .sck_rise(pins_s[1] && !pins_q[1]),
        .sdi(pins_s[0]),
        .payload_o(payload),
        .commit_o(commit)
    );

    sdac_latch #(.CW(CW), .PW(PW)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .payload(payload),
        .code_o(code_o), .fast_o(fast_o), .pdown_o(pdown_o),
        .upd_o(upd_o), .dac_o(dac_o)
    );
endmodule

// File: rtl/sdac_rx_chk.sv
module sdac_rx_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] code_o,
    input logic          fast_o,
    input logic          pdown_o,
    input logic          upd_o,
    input logic [CW-1:0] dac_o
);
    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o); // R9
    AST_CODE_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(code_o)); // R9
    AST_CTRL_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> ($stable(fast_o) && $stable(pdown_o))); // R9
    AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && pdown_o) |-> $stable(code_o)); // R5
    AST_PD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && pdown_o) |=> (dac_o == '0)); // R5
endmodule

bind sdac_rx sdac_rx_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .code_o(code_o), .fast_o(fast_o),
    .pdown_o(pdown_o), .upd_o(upd_o), .dac_o(dac_o)
);

// File: tb/sdac_rx_tb.sv
module sdac_rx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_pin = 1'b1, frm_pin = 1'b1, sck_pin = 1'b1, sdi_pin = 1'b0;
    logic [11:0] code_o, dac_o;
    logic fast_o, pdown_o, upd_o;
    int checks = 0, errors = 0, upd_cnt = 0, upd_run = 0, upd_wide = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdac_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .frm_pin(frm_pin),
        .sck_pin(sck_pin), .sdi_pin(sdi_pin), .code_o(code_o), .fast_o(fast_o),
        .pdown_o(pdown_o), .upd_o(upd_o), .dac_o(dac_o)
    );

    always @(posedge clk) begin
        if (upd_o) begin
            upd_cnt <= upd_cnt + 1;
            upd_run <= upd_run + 1;
            if (upd_run >= 1) upd_wide <= upd_wide + 1;
        end else begin
            upd_run <= 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift nbits of w (MSB first); mode 0 = commit by sclk rise, 1 = by frame rise, 2 = stop after nbits
    task automatic send(input logic [15:0] w, input int nbits, input int mode);
        frm_pin = 1'b1; sck_pin = 1'b1; gap(4);
        frm_pin = 1'b0; gap(4);
        for (int i = 15; i > 15 - nbits; i--) begin
            sdi_pin = w[i]; gap(4);
            sck_pin = 1'b0; gap(4);
            if (i != 0 || mode == 0) begin
                sck_pin = 1'b1; gap(4);
            end
        end
        if (mode == 1) begin
            frm_pin = 1'b1; gap(4);
            sck_pin = 1'b1; gap(4);
        end
        gap(10);
        frm_pin = 1'b1; gap(4);
    endtask

    task automatic expect_out(input string tag, input int code, input int fast,
                              input int pd, input int ups);
        chk({tag, " code"}, code_o, code);
        chk({tag, " fast"}, fast_o, fast);
        chk({tag, " pdown"}, pdown_o, pd);
        chk({tag, " dac"}, dac_o, pd ? 0 : code);
        chk({tag, " strobes"}, upd_cnt, ups);
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 0, 0, 0, 0);
        chk("R1 upd", upd_o, 0);
    endtask

    task automatic t_sclk_commit();
        cs_n_pin = 1'b0; gap(4);
        send(16'h0ABC, 16, 0);
        expect_out("R2 sclk commit", 12'hABC, 0, 0, 1);
    endtask

    task automatic t_fs_commit();
        send(16'h0357, 16, 1);
        expect_out("R3 frame commit", 12'h357, 0, 0, 2);
    endtask

    task automatic t_dont_care();
        send(16'h9FFF, 16, 0);
        expect_out("R11 bits 15/12", 12'hFFF, 0, 0, 3);
    endtask

    task automatic t_fast();
        send(16'h4800, 16, 0);
        expect_out("R4 fast", 12'h800, 1, 0, 4);
    endtask

    task automatic t_pdown();
        send(16'h2123, 16, 1);
        expect_out("R5 power-down", 12'h800, 0, 1, 5);
    endtask

    task automatic t_release();
        send(16'h0800, 16, 0);
        expect_out("R6 release", 12'h800, 0, 0, 6);
    endtask

    task automatic t_cs_abort();
        send(16'h4123, 7, 2);
        cs_n_pin = 1'b1; gap(8);
        cs_n_pin = 1'b0; gap(4);
        sck_pin = 1'b1; gap(8);
        expect_out("R7 select abort", 12'h800, 0, 0, 6);
    endtask

    task automatic t_restart();
        send(16'h6FFF, 5, 2);
        send(16'h0555, 16, 0);
        expect_out("R8 restart", 12'h555, 0, 0, 7);
    endtask

    task automatic t_deselected();
        cs_n_pin = 1'b1; gap(4);
        send(16'h4AAA, 16, 0);
        expect_out("R10 deselected", 12'h555, 0, 0, 7);
        cs_n_pin = 1'b0; gap(4);
    endtask

    task automatic t_strobe_width();
        chk("R9 strobe width", upd_wide, 0);
        chk("R9 strobe idle", upd_o, 0);
    endtask

    initial begin
        gap(3);
        rst_n = 1'b1;
        gap(4);
        t_reset();
        t_sclk_commit();
        t_fs_commit();
        t_dont_care();
        t_fast();
        t_pdown();
        t_release();
        t_cs_abort();
        t_restart();
        t_deselected();
        t_strobe_width();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule